// File: doc/BRIEF.md
# Transmit History Log

This block keeps a short record of the frames a CAN transmitter has delivered successfully. Each record pairs the user tag that the host attached to the frame with a time tag. The time tag is read from a free-running counter inside the block at the instant the acknowledge slot of the frame is seen, not when the record is written. The transmit engine reports the acknowledge slot first and then the final outcome of the frame. The time tag it captured is logged only when that outcome is a success. A failed outcome (abort, lost arbitration or bus error) discards it.

The host empties the log one record at a time. Each record is taken by a decoded serial command byte; the shift logic is outside the block and presents the byte together with a valid strobe. The block returns the oldest record one cycle later and removes it from the log. Empty, full, fill level and a sticky overflow flag are always visible. When the log is full, a new success pushes out the oldest record.

Top module: `tx_history_log`

## Requirements
- R1: `free_count` is a TS_W-bit counter (16 bits by default). It is zero in reset, increments by one on every clock after reset and wraps from all ones to zero.
- R2: A pulse on `ack_slot` captures the `free_count` value of that cycle. A later `tx_done` pulse with `tx_fail` low stores a record holding `tx_tag` and that captured value. If `ack_slot` is high in the same cycle as `tx_done`, or no value is held, the record takes `free_count` of the `tx_done` cycle instead.
- R3: `tx_fail` clears any held time tag and stores nothing. A `tx_fail` in the same cycle as `tx_done` wins, and no record is written.
- R4: A cycle with `cmd_valid` high and `cmd_byte` equal to 0xEE is a read. In the next cycle `rd_valid` is 1, and `rd_tag`/`rd_time` carry the oldest record, which is removed from the log. Records come out in the order in which they were stored.
- R5: A read of an empty log gives `rd_valid` = 1 with `rd_tag` and `rd_time` both zero, and the log stays empty.
- R6: A `cmd_valid` cycle with any other byte value leaves `rd_valid` at 0 in the next cycle and does not change the fill level.
- R7: The log holds up to DEPTH records (eight by default). `log_count` is the fill level, `log_empty` is 1 when it is 0, and `log_full` is 1 when it equals DEPTH.
- R8: A success that arrives while the log is full and no read is taking place drops the oldest record, stores the new one and sets `overflow`. `overflow` stays 1 until reset.
- R9: A read and a success in the same cycle on a full log return the oldest record and store the new one. The log stays full and `overflow` does not change.
- R10: Right after reset the log is empty, `overflow` and `rd_valid` are 0, and no time tag is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ack_slot | input | 1 | Acknowledge slot seen for the frame being sent |
| tx_done | input | 1 | Frame completed successfully |
| tx_fail | input | 1 | Frame aborted, lost arbitration or hit an error |
| tx_tag | input | TAG_W | User tag of the completing frame |
| cmd_valid | input | 1 | Decoded command byte strobe |
| cmd_byte | input | 8 | Command byte from the serial interface |
| rd_valid | output | 1 | Read response valid |
| rd_tag | output | TAG_W | Tag of the record read |
| rd_time | output | TS_W | Time tag of the record read |
| log_count | output | $clog2(DEPTH+1) | Records stored |
| log_empty | output | 1 | Log holds no record |
| log_full | output | 1 | Log holds DEPTH records |
| overflow | output | 1 | Sticky: a record was dropped |
| free_count | output | TS_W | Free-running time counter |

## Verification
The bench builds the block with DEPTH = 4, TS_W = 10 and TAG_W = 6. With a depth of four, filling the log, overwriting on a full log and a read and a success together on a full log each take only a few cycles. A 10-bit counter wraps about every thousand cycles, so the random phase crosses the wrap point several times. Time tags captured just before a wrap are therefore logged and read back after it.

// File: rtl/txh_pkg.sv
package txh_pkg;
  localparam logic [7:0] CMD_HIST_READ = 8'hEE;

  typedef enum logic [1:0] {
    RING_HOLD = 2'b00,
    RING_POP  = 2'b01,
    RING_PUSH = 2'b10,
    RING_SWAP = 2'b11
  } ring_op_e;
endpackage

// File: rtl/txh_timer.sv
module txh_timer #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end
endmodule

// File: rtl/txh_stamp_hold.sv
module txh_stamp_hold #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ack_slot,
  input  logic            tx_done,
  input  logic            tx_fail,
  input  logic [TS_W-1:0] now,
  output logic            push,
  output logic [TS_W-1:0] stamp
);
  logic            pending;
  logic [TS_W-1:0] held;

  // A success consumes the held stamp; a same-cycle ack supersedes it.
  assign push  = tx_done && !tx_fail;
  assign stamp = (ack_slot || !pending) ? now : held;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      held    <= '0;
    end else if (tx_fail || push) begin
      pending <= 1'b0;
    end else if (ack_slot) begin
      pending <= 1'b1;
      held    <= now;
    end
  end
endmodule

// File: rtl/txh_ring.sv
module txh_ring
  import txh_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int RW    = 24,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [RW-1:0] wr_rec,
  input  logic          rd_req,
  output logic          rd_valid,
  output logic [RW-1:0] rd_rec,
  output logic [CW-1:0] count,
  output logic          ovf
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [RW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full, pop, overwrite;
  ring_op_e      op;

  assign full      = (count == FULL);
  assign pop       = rd_req && (count != '0);
  assign overwrite = push && full && !pop;
  assign op        = ring_op_e'({push, pop});

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // Storage: write port without reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_rec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      ovf      <= 1'b0;
      rd_valid <= 1'b0;
      rd_rec   <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_rec <= pop ? mem[rd_ptr] : '0;
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop || overwrite) rd_ptr <= bump(rd_ptr);
      if (overwrite) ovf <= 1'b1;
      unique case (op)
        RING_PUSH: if (!full) count <= count + 1'b1;
        RING_POP:  count <= count - 1'b1;
        default:   count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tx_history_log.sv
module tx_history_log
  import txh_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  parameter int TS_W  = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int RW   = TAG_W + TS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_slot,
  input  logic             tx_done,
  input  logic             tx_fail,
  input  logic [TAG_W-1:0] tx_tag,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TS_W-1:0]  rd_time,
  output logic [CW-1:0]    log_count,
  output logic             log_empty,
  output logic             log_full,
  output logic             overflow,
  output logic [TS_W-1:0]  free_count
);
  logic            push, rd_req;
  logic [TS_W-1:0] stamp;
  logic [RW-1:0]   rd_rec;

  assign rd_req = cmd_valid && (cmd_byte == CMD_HIST_READ);

  txh_timer #(.TS_W(TS_W)) u_timer (
    .clk(clk), .rst(rst), .count(free_count)
  );

  txh_stamp_hold #(.TS_W(TS_W)) u_hold (
    .clk(clk), .rst(rst), .ack_slot(ack_slot), .tx_done(tx_done),
    .tx_fail(tx_fail), .now(free_count), .push(push), .stamp(stamp)
  );

  txh_ring #(.DEPTH(DEPTH), .RW(RW)) u_ring (
    .clk(clk), .rst(rst), .push(push), .wr_rec({tx_tag, stamp}),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_rec(rd_rec),
    .count(log_count), .ovf(overflow)
  );

  assign rd_tag    = rd_rec[RW-1:TS_W];
  assign rd_time   = rd_rec[TS_W-1:0];
  assign log_empty = (log_count == '0);
  assign log_full  = (log_count == CW'(DEPTH));
endmodule

// File: rtl/txh_checker.sv
module txh_checker #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  parameter int TS_W  = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_done,
  input logic             tx_fail,
  input logic             cmd_valid,
  input logic [7:0]       cmd_byte,
  input logic             rd_valid,
  input logic [TAG_W-1:0] rd_tag,
  input logic [TS_W-1:0]  rd_time,
  input logic [CW-1:0]    log_count,
  input logic             log_empty,
  input logic             log_full,
  input logic             overflow,
  input logic [TS_W-1:0]  free_count
);
  logic rd_cmd;
  assign rd_cmd = cmd_valid && (cmd_byte == 8'hEE);

  p_timer_step_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> free_count == $past(free_count) + 1'b1);

  p_fail_no_store_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_fail && !rd_cmd) |=> log_count == $past(log_count));

  p_empty_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd && log_empty) |=> rd_valid && rd_tag == '0 && rd_time == '0);

  p_other_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !rd_cmd) |=> !rd_valid);

  p_bounds_r7: assert property (@(posedge clk) disable iff (rst)
    log_count <= CW'(DEPTH) && !(log_empty && log_full));

  p_overwrite_r8: assert property (@(posedge clk) disable iff (rst)
    (log_full && tx_done && !tx_fail && !rd_cmd) |=> overflow && log_full);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_swap_full_r9: assert property (@(posedge clk) disable iff (rst)
    (log_full && tx_done && !tx_fail && rd_cmd) |=> log_full && overflow == $past(overflow));
endmodule

bind tx_history_log txh_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst(rst), .tx_done(tx_done), .tx_fail(tx_fail),
  .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .rd_valid(rd_valid),
  .rd_tag(rd_tag), .rd_time(rd_time), .log_count(log_count),
  .log_empty(log_empty), .log_full(log_full), .overflow(overflow),
  .free_count(free_count)
);

// File: tb/tb_tx_history_log.sv
module tb_tx_history_log;
  localparam int DEPTH = 4;
  localparam int TAG_W = 6;
  localparam int TS_W  = 10;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int TMASK = (1 << TS_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ack_slot = 1'b0, tx_done = 1'b0, tx_fail = 1'b0;
  logic [TAG_W-1:0] tx_tag = '0;
  logic             cmd_valid = 1'b0;
  logic [7:0]       cmd_byte = '0;
  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [TS_W-1:0]  rd_time;
  logic [CW-1:0]    log_count;
  logic             log_empty, log_full, overflow;
  logic [TS_W-1:0]  free_count;

  tx_history_log #(.DEPTH(DEPTH), .TAG_W(TAG_W), .TS_W(TS_W)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done_flag = 0;

  // Reference model state
  int m_time = 0, m_held = 0, m_ovf = 0;
  bit m_pend = 0;
  int q_tag[$], q_ts[$];
  bit e_rv;
  int e_tag, e_ts;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  // Apply the current inputs for one clock; data_req labels the read data check.
  task automatic step(string data_req);
    bit rd, push;
    int ts;
    rd   = cmd_valid && (cmd_byte == 8'hEE);
    push = tx_done && !tx_fail;
    e_rv = rd;
    if (rd) begin
      if (q_tag.size() == 0) begin e_tag = 0; e_ts = 0; end
      else begin e_tag = q_tag.pop_front(); e_ts = q_ts.pop_front(); end
    end
    ts = (ack_slot || !m_pend) ? m_time : m_held;
    if (push) begin
      if (q_tag.size() == DEPTH) begin
        void'(q_tag.pop_front()); void'(q_ts.pop_front()); m_ovf = 1;
      end
      q_tag.push_back(int'(tx_tag)); q_ts.push_back(ts);
    end
    if (tx_fail || push) m_pend = 0;
    else if (ack_slot) begin m_pend = 1; m_held = m_time; end
    m_time = (m_time + 1) & TMASK;
    @(posedge clk);
    @(negedge clk);
    ack_slot = 0; tx_done = 0; tx_fail = 0; cmd_valid = 0;
    chk("R1", int'(free_count), m_time);
    chk("R4", int'(rd_valid), int'(e_rv));
    if (e_rv) begin
      chk(data_req, int'(rd_tag), e_tag);
      chk(data_req, int'(rd_time), e_ts);
    end
    chk("R7", int'(log_count), q_tag.size());
    chk("R7", int'(log_empty), int'(q_tag.size() == 0));
    chk("R7", int'(log_full), int'(q_tag.size() == DEPTH));
    chk("R8", int'(overflow), m_ovf);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step("R4");
  endtask

  task automatic success(int tag);
    tx_done = 1; tx_tag = TAG_W'(tag);
  endtask

  task automatic read_cmd();
    cmd_valid = 1; cmd_byte = 8'hEE;
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R10: state held in reset
    chk("R10", int'(log_empty), 1);
    chk("R10", int'(overflow), 0);
    chk("R10", int'(rd_valid), 0);
    chk("R10", int'(free_count), 0);
    rst = 0;

    // R2: stamp taken at ack, logged at a later success
    idle(2);
    ack_slot = 1; step("R2");
    idle(3);
    success(5); step("R2");
    read_cmd(); step("R2");

    // R3: failure drops the held stamp; success later uses its own cycle
    ack_slot = 1; step("R3");
    tx_fail = 1; step("R3");
    idle(2);
    success(7); step("R3");
    read_cmd(); step("R3");
    success(9); tx_fail = 1; step("R3");
    chk("R3", int'(log_count), 0);

    // R5: read of an empty log
    read_cmd(); step("R5");
    chk("R5", int'(log_count), 0);

    // R6: non-read command byte is ignored
    success(11); step("R6");
    cmd_valid = 1; cmd_byte = 8'h12; step("R6");
    chk("R6", int'(rd_valid), 0);
    chk("R6", int'(log_count), 1);

    // R7/R9: fill, then read and success together while full
    for (int i = 0; i < DEPTH - 1; i++) begin success(20 + i); step("R7"); end
    chk("R7", int'(log_full), 1);
    read_cmd(); success(33); step("R9");
    chk("R9", int'(log_full), 1);
    chk("R9", int'(overflow), 0);

    // R8: success on a full log drops the oldest
    ack_slot = 1; success(40); step("R8");
    chk("R8", int'(overflow), 1);
    for (int i = 0; i < DEPTH + 1; i++) begin read_cmd(); step("R4"); end

    // Random traffic across several counter wraps
    for (int i = 0; i < 3000; i++) begin
      ack_slot  = ($urandom_range(0, 99) < 30);
      tx_done   = ($urandom_range(0, 99) < 25);
      tx_fail   = ($urandom_range(0, 99) < 8);
      tx_tag    = TAG_W'($urandom);
      cmd_valid = ($urandom_range(0, 99) < 22);
      if ($urandom_range(0, 99) < 75) cmd_byte = 8'hEE;
      else begin
        cmd_byte = 8'($urandom);
        if (cmd_byte == 8'hEE) cmd_byte = 8'h12;
      end
      step("R4");
    end
    done_flag = 1;
    finish_run();
  end
endmodule